// File: doc/BRIEF.md
# Load/Store Port Scratch Memory

This block is a small single-port scratch memory that sits behind a processor-style load/store port. A requester asks for a load or a store by raising the matching request pin together with a byte count, an address and an address-valid flag. The block takes the request while it is idle, answers with an address acknowledge, and then completes the data phase. A store delivers its write data as a strobe that lasts one clock cycle. A load returns its read data with a valid flag, and that flag stays up until the requester drops the load request.

The storage is 32 words of 64 bits. Each access falls inside one word and is positioned by the three low address bits. A byte mask is built from the byte count and that offset. Store data is taken from the low bytes of the write bus and moved up into its lanes. Load data is moved down to bit 0 and the bytes above the access length are cleared to zero, so the lane order is little-endian. Bytes that would fall past the end of the word are dropped on a store and read as zero on a load.

Top module: `lsport_scratch`

## Requirements
- R1: After reset, busy, the address acknowledge and the load-data-valid outputs are low, and every memory byte reads as zero.
- R2: The block accepts a request only while idle, with the address-valid flag high, exactly one of the load and store requests high, and a byte count of 1, 2, 4 or 8 (the count is given as a plain binary number). Any other combination leaves the block idle.
- R3: Busy and the address acknowledge rise on the clock edge that accepts a request and stay high until the access ends.
- R4: A store writes memory on the one edge where the store strobe is high while the block waits for store data, and then returns to idle on that same edge. A store strobe at any other time has no effect.
- R5: A store of N bytes at offset K (address bits [2:0]) writes byte i of the write data into lane K+i for every i below N with K+i at most 7. All other lanes of the word keep their values.
- R6: A load of N bytes at offset K returns lane K+i in byte i for every i below N with K+i at most 7. All other bytes of the result are zero.
- R7: Load data becomes valid on the second clock edge after acceptance, stays valid while the load request is held high, and clears on the first edge where the load request is low.
- R8: Lanes are little-endian: a 2-byte store of 0xBEEF at 0x04 and a 2-byte store of 0xF00F at 0x06 read back as 0xF00FBEEF from a 4-byte load at 0x04.
- R9: Address bits [7:3] choose the word. Address bits 8 and up have no effect on which word is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_req_i | input | 1 | Load request |
| st_req_i | input | 1 | Store request |
| len_i | input | 4 | Access byte count (1, 2, 4 or 8) |
| addr_i | input | 48 | Byte address |
| addr_vld_i | input | 1 | Address valid |
| addr_ack_o | output | 1 | Address accepted; held for the whole access |
| st_data_i | input | 64 | Store data, right-aligned |
| st_vld_i | input | 1 | One-cycle store data strobe |
| ld_data_o | output | 64 | Load data, right-aligned and zero-extended |
| ld_vld_o | output | 1 | Load data valid |
| busy_o | output | 1 | Access in progress |

## Verification
On every cycle the assertions check four things: busy only rises after a well-formed request was presented, a store strobe during the wait ends the access on the next edge, load-valid holds and drops in step with the load request, and the number of enabled lanes equals the byte count clipped at the word end. Only the bench scenarios can show that the right bytes reach the right lanes and come back. The bench sweeps every byte count at every offset against its own byte-level model. It also checks that the other lanes survive, that addresses alias above bit 7, that malformed and stray requests are ignored, and the exact cycles of the handshake.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWAIT  = 2'd1,
    ST_LREAD  = 2'd2,
    ST_LHOLD  = 2'd3
  } lsp_state_e;

  // Legal access sizes are single powers of two up to a full word.
  function automatic logic len_ok(input logic [7:0] n);
    return (n == 8'd1) || (n == 8'd2) || (n == 8'd4) || (n == 8'd8);
  endfunction

endpackage

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
  import lsp_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int OFF_W = 3,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req_i,
  input  logic             st_req_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             addr_vld_i,
  input  logic             st_vld_i,
  output logic             addr_ack_o,
  output logic             busy_o,
  output logic             ld_vld_o,
  output logic             wr_en_o,
  output logic             ld_cap_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [OFF_W-1:0] off_o,
  output logic [LEN_W-1:0] len_o
);

  lsp_state_e state_q, state_d;
  logic       accept;

  assign accept = (state_q == ST_IDLE) && addr_vld_i && (ld_req_i ^ st_req_i)
                  && len_ok(8'(len_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = st_req_i ? ST_SWAIT : ST_LREAD;
      ST_SWAIT: if (st_vld_i) state_d = ST_IDLE;
      ST_LREAD: state_d = ST_LHOLD;
      ST_LHOLD: if (!ld_req_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_o   <= '0;
      off_o   <= '0;
      len_o   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_o <= idx_i;
        off_o <= off_i;
        len_o <= len_i;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign addr_ack_o = (state_q != ST_IDLE);
  assign ld_vld_o   = (state_q == ST_LHOLD);
  assign wr_en_o    = (state_q == ST_SWAIT) && st_vld_i;
  assign ld_cap_o   = (state_q == ST_LREAD);

  // R2: busy can only begin after a well-formed request was on the pins
  a_r2_accept_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(addr_vld_i && (ld_req_i ^ st_req_i)));

  // R4: the store strobe while waiting closes the access
  a_r4_store_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ld_vld_o && !ld_cap_o && st_vld_i) |=> !busy_o);

  // R7: load-valid is held while the load request stays high
  a_r7_ldvld_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld_o && ld_req_i) |=> ld_vld_o);

  // R7: load-valid falls once the load request is withdrawn
  a_r7_ldvld_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld_o && !ld_req_i) |=> (!ld_vld_o && !busy_o));

endmodule

// File: rtl/lsp_lane_map.sv
module lsp_lane_map #(
  parameter int LANES = 8,
  parameter int OFF_W = 3,
  parameter int LEN_W = 4,
  localparam int DW   = LANES * 8
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    st_data_i,
  input  logic [DW-1:0]    rd_word_i,
  output logic [LANES-1:0] mask_o,
  output logic [DW-1:0]    wr_word_o,
  output logic [DW-1:0]    ld_data_o
);

  localparam int SUM_W = (OFF_W > LEN_W ? OFF_W : LEN_W) + 1;

  logic [SUM_W-1:0] off_x, end_x;
  logic [DW-1:0]    rd_down;

  assign off_x     = SUM_W'(off_i);
  assign end_x     = SUM_W'(off_i) + SUM_W'(len_i);
  assign wr_word_o = st_data_i << {off_i, 3'b000};
  assign rd_down   = rd_word_i >> {off_i, 3'b000};

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign mask_o[b] = (SUM_W'(b) >= off_x) && (SUM_W'(b) < end_x);
    assign ld_data_o[b*8 +: 8] = (SUM_W'(b) < SUM_W'(len_i)) ? rd_down[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsp_mem.sv
module lsp_mem #(
  parameter int LANES = 8,
  parameter int DEPTH = 32,
  localparam int DW    = LANES * 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else if (wr_en_i) begin
      for (int b = 0; b < LANES; b++)
        if (mask_i[b]) mem_q[idx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/lsport_scratch.sv
module lsport_scratch #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  output logic              addr_ack_o,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_vld_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_vld_o,
  output logic              busy_o
);

  logic              wr_en, ld_cap;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  len_q;
  logic [LANES-1:0]  mask;
  logic [DATA_W-1:0] wr_word, rd_word, ld_word, ld_data_q;

  lsp_ctrl #(.IDX_W(IDX_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_req_i   (ld_req_i),
    .st_req_i   (st_req_i),
    .len_i      (len_i),
    .idx_i      (addr_i[OFF_W +: IDX_W]),
    .off_i      (addr_i[OFF_W-1:0]),
    .addr_vld_i (addr_vld_i),
    .st_vld_i   (st_vld_i),
    .addr_ack_o (addr_ack_o),
    .busy_o     (busy_o),
    .ld_vld_o   (ld_vld_o),
    .wr_en_o    (wr_en),
    .ld_cap_o   (ld_cap),
    .idx_o      (idx_q),
    .off_o      (off_q),
    .len_o      (len_q)
  );

  lsp_lane_map #(.LANES(LANES), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_lanes (
    .off_i     (off_q),
    .len_i     (len_q),
    .st_data_i (st_data_i),
    .rd_word_i (rd_word),
    .mask_o    (mask),
    .wr_word_o (wr_word),
    .ld_data_o (ld_word)
  );

  lsp_mem #(.LANES(LANES), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .idx_i   (idx_q),
    .mask_i  (mask),
    .wdata_i (wr_word),
    .rdata_o (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ld_data_q <= '0;
    else if (ld_cap) ld_data_q <= ld_word;
  end

  assign ld_data_o = ld_data_q;

  // R5: enabled lanes equal the byte count, clipped at the end of the word
  a_r5_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(mask) ==
               ((32'(off_q) + 32'(len_q) > LANES) ? (LANES - 32'(off_q)) : 32'(len_q))));

endmodule

// File: tb/tb_lsport_scratch.sv
`timescale 1ns/1ps
module tb_lsport_scratch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req_i = 1'b0, st_req_i = 1'b0, addr_vld_i = 1'b0, st_vld_i = 1'b0;
  logic [3:0]  len_i = '0;
  logic [47:0] addr_i = '0;
  logic [63:0] st_data_i = '0;
  logic        addr_ack_o, ld_vld_o, busy_o;
  logic [63:0] ld_data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  byte unsigned model [256];

  always #2 clk = ~clk;

  lsport_scratch dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_ld(input logic [47:0] a, input int n);
    logic [63:0] r = '0;
    int base = int'(a[7:3]) * 8;
    int off  = int'(a[2:0]);
    for (int i = 0; i < n; i++)
      if (off + i < 8) r[i*8 +: 8] = model[base + off + i];
    return r;
  endfunction

  task automatic do_store(input logic [47:0] a, input int n, input logic [63:0] d);
    int base = int'(a[7:3]) * 8;
    int off  = int'(a[2:0]);
    @(negedge clk);
    st_req_i = 1; len_i = 4'(n); addr_i = a; addr_vld_i = 1;
    @(negedge clk);
    while (!addr_ack_o) @(negedge clk);
    st_data_i = d; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0; st_req_i = 0; addr_vld_i = 0;
    for (int i = 0; i < n; i++)
      if (off + i < 8) model[base + off + i] = d[i*8 +: 8];
  endtask

  task automatic do_load(input logic [47:0] a, input int n, output logic [63:0] d);
    @(negedge clk);
    ld_req_i = 1; len_i = 4'(n); addr_i = a; addr_vld_i = 1;
    @(negedge clk);
    while (!ld_vld_o) @(negedge clk);
    d = ld_data_o;
    ld_req_i = 0; addr_vld_i = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] d, pat;
    foreach (model[i]) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset and after release
    chk("R1 busy", 64'(busy_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ack", 64'(addr_ack_o), 0);
    chk("R1 ldvld", 64'(ld_vld_o), 0);
    for (int w = 0; w < 32; w += 7) begin
      do_load(48'(w * 8), 8, d);
      chk("R1 zero memory", d, 64'h0);
    end

    // R3 / R7: exact handshake cycles for a load
    @(negedge clk);
    ld_req_i = 1; len_i = 8; addr_i = 48'h10; addr_vld_i = 1;
    chk("R3 idle before edge", 64'(busy_o), 0);
    @(negedge clk);
    chk("R3 busy after accept", 64'(busy_o), 1);
    chk("R3 ack after accept", 64'(addr_ack_o), 1);
    chk("R7 not yet valid", 64'(ld_vld_o), 0);
    @(negedge clk);
    chk("R7 valid second edge", 64'(ld_vld_o), 1);
    repeat (2) @(negedge clk);
    chk("R7 valid held", 64'(ld_vld_o), 1);
    ld_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    chk("R7 valid cleared", 64'(ld_vld_o), 0);
    chk("R3 busy cleared", 64'(busy_o), 0);

    // R4: store waits for strobe, busy meanwhile, ends on strobe edge
    @(negedge clk);
    st_req_i = 1; len_i = 8; addr_i = 48'h20; addr_vld_i = 1;
    repeat (3) @(negedge clk);
    chk("R4 waiting busy", 64'(busy_o), 1);
    st_data_i = 64'h0123_4567_89AB_CDEF; st_vld_i = 1;
    @(negedge clk);
    chk("R4 ends on strobe", 64'(busy_o), 0);
    st_vld_i = 0; st_req_i = 0; addr_vld_i = 0;
    for (int i = 0; i < 8; i++) model[32 + i] = st_data_i[i*8 +: 8];
    do_load(48'h20, 8, d);
    chk("R4 store written", d, expect_ld(48'h20, 8));

    // R4: stray strobe while idle is ignored
    @(negedge clk);
    st_data_i = '1; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0;
    chk("R4 stray strobe no busy", 64'(busy_o), 0);
    do_load(48'h20, 8, d);
    chk("R4 stray strobe ignored", d, expect_ld(48'h20, 8));

    // R2: malformed requests stay idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      case (k)
        0: begin st_req_i = 1; len_i = 3; addr_vld_i = 1; end
        1: begin ld_req_i = 1; st_req_i = 1; len_i = 4; addr_vld_i = 1; end
        2: begin st_req_i = 1; len_i = 4; addr_vld_i = 0; end
        default: begin len_i = 4; addr_vld_i = 1; end
      endcase
      st_data_i = '1; st_vld_i = 1; addr_i = 48'h20;
      repeat (2) @(negedge clk);
      chk("R2 rejected no ack", 64'(addr_ack_o), 0);
      chk("R2 rejected no busy", 64'(busy_o), 0);
      ld_req_i = 0; st_req_i = 0; addr_vld_i = 0; st_vld_i = 0;
    end
    do_load(48'h20, 8, d);
    chk("R2 rejected no write", d, expect_ld(48'h20, 8));

    // R8: little-endian halfwords
    do_store(48'h04, 2, 64'hBEEF);
    do_store(48'h06, 2, 64'hF00F);
    do_load(48'h04, 2, d); chk("R8 first half", d, 64'hBEEF);
    do_load(48'h06, 2, d); chk("R8 second half", d, 64'hF00F);
    do_load(48'h04, 4, d); chk("R8 joined word", d, 64'hF00FBEEF);

    // R5 / R6: every size at every offset, with a full-word background
    for (int s = 0; s < 4; s++) begin
      for (int off = 0; off < 8; off++) begin
        logic [47:0] a;
        a = 48'((s * 8 + off) + 8 * 8);
        pat = {8{8'h5A}} ^ {32'(s * 8 + off + 1), 32'hC3A5_0F1E};
        do_store(48'(a & ~48'h7), 8, ~pat);
        do_store(a, 1 << s, pat);
        do_load(48'(a & ~48'h7), 8, d);
        chk("R5 lanes written and kept", d, expect_ld(48'(a & ~48'h7), 8));
        do_load(a, 1 << s, d);
        chk("R6 load extract", d, expect_ld(a, 1 << s));
      end
    end

    // R9: bits above 7 alias the same word
    do_store(48'h8000_0000_0138, 8, 64'hFEED_FACE_CAFE_D00D);
    do_load(48'h0000_0000_0038, 8, d);
    chk("R9 high bits ignored", d, 64'hFEED_FACE_CAFE_D00D);
    do_load(48'h0000_0000_0030, 8, d);
    chk("R9 neighbour word untouched", d, expect_ld(48'h30, 8));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule